// File: doc/BRIEF.md
# Smart Card Character Receiver with Error-Signal Retry

This block is the receive half of a half-duplex asynchronous smart card character link. It watches the serial data line with a clock-cycle counter set to one elementary time unit (ETU). It confirms the start bit halfway through it, then samples eight data bits and a parity bit in the middle of each ETU. It checks the stop bit and produces a one-cycle strobe with the assembled byte. Parity, framing and break faults are reported as one-cycle event pulses. When the caller enables retry, a parity fault does not raise a flag. Instead the receiver pulls the line low to ask the card to resend, up to a programmable number of times.

Bit convention is either direct (true levels, least significant bit first) or inverse (inverted levels, most significant bit first). While auto-convention is enabled, the first character received is taken as the initial answer-to-reset byte. Its pattern fixes the convention used for every following character. ETU generation, buffering and the transmit path live outside this block.

Top module: `sc_char_rx`

## Requirements
- R1: When idle, a falling edge on the line starts a character only if the line is still low half an ETU later. A shorter low pulse produces no strobe, no error event, and leaves `rx_active` low afterwards.
- R2: In direct convention, bit k of the byte is the true line level sampled in the middle of the (k+1)-th ETU after the start bit. A good character gives a one-cycle `rx_valid` pulse with the byte on `rx_data`.
- R3: Parity is the ninth bit. The total count of logical ones over data and parity must be even, or odd when `odd_par` is 1. With retry disabled, a mismatch pulses `par_err` in the same cycle as `rx_valid`, and the byte is still delivered.
- R4: With retry disabled, a stop bit sampled low pulses `frame_err` and suppresses `rx_valid`, unless the break condition of R5 holds.
- R5: With retry disabled, if the start, all data, the parity and the stop samples are all low, `break_err` pulses instead of `frame_err`, and no byte is delivered.
- R6: With retry enabled, a parity mismatch pulses `retry_evt` and never `par_err`, and delivers no byte. `line_pull_low` is then asserted from half an ETU after the parity sample for exactly one ETU.
- R7: Consecutive parity faults may be retried `retry_lim`+1 times. The next fault in the run pulses `over_retry`, drops the byte and does not pull the line. The run count is cleared by a good character or by the over-retry event.
- R8: With retry enabled, a low stop bit raises neither `frame_err` nor `break_err`, and delivers no byte.
- R9: While `auto_conv` is 1, the first completed character after `auto_conv` rises is the initial byte. Raw levels 0x3B (first bit as bit 0) select direct convention and report 0x3B. A pattern that decodes to 0x3F in inverse convention selects inverse and reports 0x3F. Any other value pulses `conv_err` and keeps the convention.
- R10: In inverse convention the first data bit is the byte's bit 7, every sampled level is inverted, and parity is checked on the inverted (logical) values.
- R11: With `short_stop` at 1 the receiver accepts a new start edge right after the stop sample. With `short_stop` at 0 it ignores falling edges for one more ETU.
- R12: `rx_active` is 0 after reset and while idle. It is 1 from the start edge until the character ends, including any error signaling and stop guard.
- R13: With `rx_en` at 0 the receiver returns to idle on the next edge. It then produces no strobes and releases the line.

Port order below matches the module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| etu_cycles | input | ETU_W | Clock cycles per ETU |
| odd_par | input | 1 | 1 selects odd parity |
| short_stop | input | 1 | 1 selects a one-ETU stop period |
| retry_en | input | 1 | Enables error-signal retry |
| retry_lim | input | RETRY_W | Retry limit minus one |
| auto_conv | input | 1 | Treat first character as convention byte |
| line_in | input | 1 | Serial data line |
| line_pull_low | output | 1 | Drive the data line low (error signal) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle byte strobe |
| par_err | output | 1 | Parity fault event |
| frame_err | output | 1 | Stop-bit fault event |
| break_err | output | 1 | Break event |
| retry_evt | output | 1 | A retry was requested |
| over_retry | output | 1 | Retry limit exceeded |
| conv_inverse | output | 1 | Current convention is inverse |
| conv_err | output | 1 | Initial byte was not a convention pattern |
| rx_active | output | 1 | A character is in progress |

## Verification
The assertions assume `etu_cycles` is at least 8 and stays fixed during a character. They also assume `retry_lim` is not changed while a run of retries is open. The bench meets both by changing configuration only between characters, with the line idle high for several ETUs, and by using ETU lengths from 16 to 24 cycles. It also assumes the line is synchronous with the bench-driven ETU grid, with no jitter. This is kept by driving every bit for a whole number of ETUs from the falling clock edge.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] TS_DIRECT  = 8'h3B;
  localparam logic [BYTE_W-1:0] TS_INVERSE = 8'h3F;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_ERRW, S_ERRD, S_STOP, S_GUARD
  } rx_state_e;

  function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

  // raw[0] is the first bit on the line
  function automatic logic [BYTE_W-1:0] decode_byte(input logic [BYTE_W-1:0] raw,
                                                    input logic inv);
    return inv ? ~bit_rev(raw) : raw;
  endfunction

  // nine inverted levels flip the xor once when inverse
  function automatic logic parity_ok(input logic [BYTE_W-1:0] raw, input logic par_raw,
                                     input logic inv, input logic odd);
    return ((^raw) ^ par_raw ^ inv) == odd;
  endfunction

  function automatic logic ts_is_direct(input logic [BYTE_W-1:0] raw);
    return raw == TS_DIRECT;
  endfunction

  function automatic logic ts_is_inverse(input logic [BYTE_W-1:0] raw);
    return decode_byte(raw, 1'b1) == TS_INVERSE;
  endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign dout = sh[STAGES-1];
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/sc_rx_retry.sv
module sc_rx_retry #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lim,
  input  logic         bump,
  input  logic         clear,
  output logic         allow
);
  logic [W:0] count;

  assign allow = (count <= {1'b0, lim});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= count + 1'b1;
  end

  // R7: a run never counts beyond the largest legal limit plus one
  a_r7_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (W+1)'(1 << W));
endmodule

// File: rtl/sc_rx_conv.sv
module sc_rx_conv
  import sc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              commit,
  input  logic [BYTE_W-1:0] raw,
  output logic              inv,
  output logic              pending,
  output logic              err
);
  logic seen;

  assign pending = auto_en & ~seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      inv  <= 1'b0;
      err  <= 1'b0;
    end else begin
      err <= 1'b0;
      if (!auto_en) seen <= 1'b0;
      else if (commit) begin
        seen <= 1'b1;
        if (ts_is_direct(raw))       inv <= 1'b0;
        else if (ts_is_inverse(raw)) inv <= 1'b1;
        else                         err <= 1'b1;
      end
    end
  end

  // R9: convention only moves on a committed initial byte
  a_r9_conv_only_on_ts: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inv) |-> $past(commit));
  a_r9_err_only_on_ts: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(commit) && $stable(inv));
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int ETU_W       = 12,
  parameter int RETRY_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic [ETU_W-1:0]   etu_cycles,
  input  logic               odd_par,
  input  logic               short_stop,
  input  logic               retry_en,
  input  logic [RETRY_W-1:0] retry_lim,
  input  logic               auto_conv,
  input  logic               line_in,
  output logic               line_pull_low,
  output logic [BYTE_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               par_err,
  output logic               frame_err,
  output logic               break_err,
  output logic               retry_evt,
  output logic               over_retry,
  output logic               conv_inverse,
  output logic               conv_err,
  output logic               rx_active
);
  localparam int BIDX_W = $clog2(BYTE_W);
  localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(BYTE_W - 1);

  logic line_s, line_fall;
  sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s), .fall(line_fall)
  );

  rx_state_e         st;
  logic [ETU_W-1:0]  cnt;
  logic [BIDX_W-1:0] bidx;
  logic [BYTE_W-1:0] raw;
  logic              all_low, cur_inv, pok, drop;

  // named internal events
  logic [ETU_W-1:0] half_etu;
  logic bit_end, half_end, use_inv_now, pok_now;
  logic par_evt, stop_evt, retry_bump, retry_over, retry_allow, retry_clear;
  logic char_good, ts_commit, ts_pending;

  assign half_etu    = etu_cycles >> 1;
  assign bit_end     = (cnt == etu_cycles - 1'b1);
  assign half_end    = (cnt == half_etu - 1'b1);
  assign use_inv_now = ts_pending ? (ts_is_inverse(raw) | (~ts_is_direct(raw) & conv_inverse))
                                  : conv_inverse;
  assign pok_now     = parity_ok(raw, line_s, use_inv_now, odd_par);
  assign par_evt     = rx_en && (st == S_PAR) && bit_end;
  assign stop_evt    = rx_en && (st == S_STOP) && bit_end;
  assign retry_bump  = par_evt && !pok_now && retry_en && retry_allow;
  assign retry_over  = par_evt && !pok_now && retry_en && !retry_allow;
  assign char_good   = stop_evt && line_s && !drop;
  assign ts_commit   = char_good && ts_pending;
  assign retry_clear = (char_good && pok) || retry_over;

  sc_rx_retry #(.W(RETRY_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .lim(retry_lim), .bump(retry_bump),
    .clear(retry_clear), .allow(retry_allow)
  );

  sc_rx_conv u_conv (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_conv), .commit(ts_commit), .raw(raw),
    .inv(conv_inverse), .pending(ts_pending), .err(conv_err)
  );

  assign rx_active     = (st != S_IDLE);
  assign line_pull_low = (st == S_ERRD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; raw <= '0;
      all_low <= 1'b0; cur_inv <= 1'b0; pok <= 1'b1; drop <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; par_err <= 1'b0; frame_err <= 1'b0;
      break_err <= 1'b0; retry_evt <= 1'b0; over_retry <= 1'b0;
    end else begin
      rx_valid <= 1'b0; par_err <= 1'b0; frame_err <= 1'b0;
      break_err <= 1'b0; retry_evt <= 1'b0; over_retry <= 1'b0;
      if (!rx_en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (line_fall) begin st <= S_START; cnt <= '0; end
          S_START: begin
            if (half_end) begin
              cnt <= '0;
              if (!line_s) begin st <= S_DATA; bidx <= '0; all_low <= 1'b1; end
              else st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (bit_end) begin
              cnt       <= '0;
              raw[bidx] <= line_s;
              all_low   <= all_low & ~line_s;
              if (bidx == LAST_BIT) st <= S_PAR;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (bit_end) begin
              cnt        <= '0;
              all_low    <= all_low & ~line_s;
              cur_inv    <= use_inv_now;
              pok        <= pok_now;
              drop       <= retry_over;
              retry_evt  <= retry_bump;
              over_retry <= retry_over;
              st         <= retry_bump ? S_ERRW : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_ERRW: begin
            if (half_end) begin st <= S_ERRD; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          S_ERRD: begin
            if (bit_end) begin st <= S_GUARD; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (bit_end) begin
              cnt <= '0;
              if (!line_s) begin
                if (!retry_en) begin
                  break_err <= all_low;
                  frame_err <= ~all_low;
                end
              end else if (!drop) begin
                rx_valid <= 1'b1;
                rx_data  <= decode_byte(raw, cur_inv);
                par_err  <= ~pok & ~retry_en;
              end
              st <= short_stop ? S_IDLE : S_GUARD;
            end else cnt <= cnt + 1'b1;
          end
          S_GUARD: begin
            if (bit_end) begin st <= S_IDLE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3: a parity event only accompanies a delivered byte, never under retry
  a_r3_par_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rx_valid && !retry_en);
  // R4, R8: stop faults drop the byte and are silent under retry
  a_r4_fault_drops_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err || break_err) |-> !rx_valid && !retry_en);
  // R5: break replaces the frame report
  a_r5_break_not_frame: assert property (@(posedge clk) disable iff (!rst_n)
    break_err |-> !frame_err);
  // R6: a retried character is not delivered and starts the error signal later
  a_r6_retry_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |-> !rx_valid && !par_err && !over_retry && !line_pull_low);
  // R13: disabling forces idle and releases the line
  a_r13_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_active && !line_pull_low);
endmodule

// File: tb/sc_char_rx_tb.sv
`timescale 1ns/1ps
module sc_char_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, odd_par = 1'b0, short_stop = 1'b0, retry_en = 1'b0, auto_conv = 1'b0;
  logic line_in = 1'b1;
  logic [11:0] etu_cycles = 12'd20;
  logic [2:0]  retry_lim = 3'd0;
  logic line_pull_low, rx_valid, par_err, frame_err, break_err, retry_evt, over_retry;
  logic conv_inverse, conv_err, rx_active;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  sc_char_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .etu_cycles(etu_cycles), .odd_par(odd_par),
    .short_stop(short_stop), .retry_en(retry_en), .retry_lim(retry_lim),
    .auto_conv(auto_conv), .line_in(line_in), .line_pull_low(line_pull_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frame_err(frame_err),
    .break_err(break_err), .retry_evt(retry_evt), .over_retry(over_retry),
    .conv_inverse(conv_inverse), .conv_err(conv_err), .rx_active(rx_active)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, nv = 0, npar = 0, nfr = 0, nbrk = 0, nret = 0, nover = 0, ncerr = 0, npull = 0;
  int pull_rise = 0, t_start = 0;
  logic pull_prev = 1'b0;
  logic [7:0] last_data = 8'h00;
  int s_nv, s_npar, s_nfr, s_nbrk, s_nret, s_nover, s_ncerr, s_npull;
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rx_valid) begin nv++; last_data = rx_data; end
      if (par_err) npar++;
      if (frame_err) nfr++;
      if (break_err) nbrk++;
      if (retry_evt) nret++;
      if (over_retry) nover++;
      if (conv_err) ncerr++;
      if (line_pull_low) begin
        npull++;
        if (!pull_prev) pull_rise = cyc;
      end
      pull_prev = line_pull_low;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic snap();
    s_nv = nv; s_npar = npar; s_nfr = nfr; s_nbrk = nbrk;
    s_nret = nret; s_nover = nover; s_ncerr = ncerr; s_npull = npull;
  endtask

  // {parity, raw}; raw[0] is the first data bit on the line
  function automatic logic [8:0] encode(input logic [7:0] b, input logic inv,
                                        input logic odd, input logic flip);
    logic [7:0] r;
    logic p;
    for (int k = 0; k < 8; k++) r[k] = inv ? ~b[7-k] : b[k];
    p = (^b) ^ odd ^ flip;
    return {inv ? ~p : p, r};
  endfunction

  task automatic wait_etu(input int n);
    repeat (n * int'(etu_cycles)) @(negedge clk);
  endtask

  task automatic send_raw(input logic [8:0] fr, input logic stop_lvl,
                          input int stop_etu, input int idle_etu);
    @(negedge clk);
    t_start = cyc;
    line_in = 1'b0;
    wait_etu(1);
    for (int i = 0; i < 9; i++) begin
      line_in = fr[i];
      wait_etu(1);
    end
    line_in = stop_lvl;
    wait_etu(1);
    line_in = 1'b1;
    if (stop_etu > 1) wait_etu(stop_etu - 1);
    if (idle_etu > 0) wait_etu(idle_etu);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic inv, input logic flip);
    send_raw(encode(b, inv, odd_par, flip), 1'b1, 2, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic fl;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12", "active after reset", int'(rx_active), 0);
    chk("R12", "valid after reset", int'(rx_valid), 0);
    chk("R9", "convention after reset", int'(conv_inverse), 0);
    chk("R6", "pull after reset", int'(line_pull_low), 0);
    rst_n = 1'b1; rx_en = 1'b1;
    wait_etu(2);

    // R1 glitch shorter than half ETU
    snap();
    line_in = 1'b0;
    repeat (int'(etu_cycles) / 4) @(negedge clk);
    line_in = 1'b1;
    wait_etu(3);
    chk("R1", "glitch strobes", nv - s_nv, 0);
    chk("R1", "glitch errors", (nfr - s_nfr) + (nbrk - s_nbrk) + (npar - s_npar), 0);
    chk("R1", "active after glitch", int'(rx_active), 0);

    // R2 directed byte, R12 active mid-character
    snap();
    fork
      send_byte(8'hA5, 1'b0, 1'b0);
      begin wait_etu(5); chk("R12", "active mid character", int'(rx_active), 1); end
    join
    chk("R2", "strobe count A5", nv - s_nv, 1);
    chk("R2", "data A5", int'(last_data), 8'hA5);
    chk("R12", "active after character", int'(rx_active), 0);

    // R2, R3 random bytes with random parity mode and injected faults
    for (int n = 0; n < 24; n++) begin
      etu_cycles = 12'(16 + ($urandom % 9));
      odd_par = 1'($urandom);
      b  = 8'($urandom);
      fl = (($urandom % 4) == 0);
      snap();
      send_byte(b, 1'b0, fl);
      chk("R2", "random strobe", nv - s_nv, 1);
      chk("R2", "random data", int'(last_data), int'(b));
      chk("R3", "random parity event", npar - s_npar, int'(fl));
    end
    etu_cycles = 12'd20;

    // R3 odd parity directed
    odd_par = 1'b1;
    snap(); send_byte(8'h0F, 1'b0, 1'b0);
    chk("R3", "odd good parity", npar - s_npar, 0);
    snap(); send_byte(8'h0F, 1'b0, 1'b1);
    chk("R3", "odd bad parity", npar - s_npar, 1);
    chk("R3", "byte kept on parity fault", nv - s_nv, 1);
    odd_par = 1'b0;

    // R4 frame error
    snap();
    send_raw(encode(8'h5A, 1'b0, 1'b0, 1'b0), 1'b0, 2, 3);
    chk("R4", "frame event", nfr - s_nfr, 1);
    chk("R4", "no strobe on frame fault", nv - s_nv, 0);

    // R5 break: all zero with even parity zero and low stop
    snap();
    send_raw(9'h000, 1'b0, 2, 3);
    chk("R5", "break event", nbrk - s_nbrk, 1);
    chk("R5", "no frame on break", nfr - s_nfr, 0);
    chk("R5", "no strobe on break", nv - s_nv, 0);

    // R6, R7 retry with limit field 1 (two retries allowed)
    retry_en = 1'b1; retry_lim = 3'd1;
    for (int k = 0; k < 2; k++) begin
      snap();
      send_byte(8'h33, 1'b0, 1'b1);
      chk("R6", "retry event", nret - s_nret, 1);
      chk("R6", "no parity flag under retry", npar - s_npar, 0);
      chk("R6", "no strobe on retry", nv - s_nv, 0);
      chk("R6", "pull length", npull - s_npull, int'(etu_cycles));
      chk("R6", "pull start window",
          int'((pull_rise - t_start) >= 190 && (pull_rise - t_start) <= 214), 1);
    end
    snap();
    send_byte(8'h33, 1'b0, 1'b1);
    chk("R7", "over retry event", nover - s_nover, 1);
    chk("R7", "no retry past limit", nret - s_nret, 0);
    chk("R7", "no pull past limit", npull - s_npull, 0);
    chk("R7", "no strobe past limit", nv - s_nv, 0);
    snap();
    send_byte(8'h33, 1'b0, 1'b1);
    chk("R7", "count cleared by over retry", nret - s_nret, 1);
    snap();
    send_byte(8'hC3, 1'b0, 1'b0);
    chk("R7", "good byte under retry", int'(last_data), 8'hC3);
    chk("R7", "good byte strobe", nv - s_nv, 1);

    // R8 stop fault under retry
    snap();
    send_raw(encode(8'h11, 1'b0, 1'b0, 1'b0), 1'b0, 2, 3);
    chk("R8", "no frame under retry", nfr - s_nfr, 0);
    chk("R8", "no strobe on stop fault", nv - s_nv, 0);
    snap();
    send_raw(9'h000, 1'b0, 2, 3);
    chk("R8", "no break under retry", nbrk - s_nbrk, 0);
    retry_en = 1'b0; retry_lim = 3'd0;

    // R11 short stop: back to back characters accepted
    short_stop = 1'b1;
    snap();
    send_raw(encode(8'h6E, 1'b0, 1'b0, 1'b0), 1'b1, 1, 0);
    send_raw(encode(8'h91, 1'b0, 1'b0, 1'b0), 1'b1, 1, 3);
    chk("R11", "short stop strobes", nv - s_nv, 2);
    chk("R11", "short stop second byte", int'(last_data), 8'h91);
    // R11 long stop: start one ETU after stop is ignored
    short_stop = 1'b0;
    snap();
    send_raw(encode(8'h6E, 1'b0, 1'b0, 1'b0), 1'b1, 1, 0);
    send_raw(9'h000, 1'b1, 2, 3);
    chk("R11", "long stop ignores early start", nv - s_nv, 1);
    chk("R11", "long stop first byte", int'(last_data), 8'h6E);

    // R9 inverse initial byte
    auto_conv = 1'b1;
    snap();
    send_byte(8'h3F, 1'b1, 1'b0);
    chk("R9", "inverse ts data", int'(last_data), 8'h3F);
    chk("R9", "inverse selected", int'(conv_inverse), 1);
    chk("R9", "no convention error", ncerr - s_ncerr, 0);

    // R10 inverse convention data
    for (int n = 0; n < 6; n++) begin
      b = 8'($urandom);
      snap();
      send_byte(b, 1'b1, 1'b0);
      chk("R10", "inverse data", int'(last_data), int'(b));
      chk("R10", "inverse parity clean", npar - s_npar, 0);
    end
    snap(); send_byte(8'h3B, 1'b1, 1'b1);
    chk("R10", "inverse parity fault", npar - s_npar, 1);

    // R9 bad initial byte keeps convention
    auto_conv = 1'b0; @(negedge clk); auto_conv = 1'b1;
    snap();
    send_byte(8'h55, 1'b1, 1'b0);
    chk("R9", "bad ts error", ncerr - s_ncerr, 1);
    chk("R9", "bad ts keeps inverse", int'(conv_inverse), 1);
    chk("R9", "bad ts data", int'(last_data), 8'h55);
    // R9 direct initial byte
    auto_conv = 1'b0; @(negedge clk); auto_conv = 1'b1;
    snap();
    send_byte(8'h3B, 1'b0, 1'b0);
    chk("R9", "direct selected", int'(conv_inverse), 0);
    chk("R9", "direct ts data", int'(last_data), 8'h3B);
    snap(); send_byte(8'h3F, 1'b0, 1'b0);
    chk("R9", "later byte not a ts", int'(conv_inverse), 0);
    chk("R9", "later byte no error", ncerr - s_ncerr, 0);
    auto_conv = 1'b0;

    // R13 disabled receiver
    rx_en = 1'b0;
    snap();
    send_byte(8'h77, 1'b0, 1'b0);
    chk("R13", "no strobe when disabled", nv - s_nv, 0);
    chk("R13", "idle when disabled", int'(rx_active), 0);
    rx_en = 1'b1;
    wait_etu(1);
    snap();
    fork
      send_byte(8'h77, 1'b0, 1'b0);
      begin
        wait_etu(4);
        rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R13", "active drops on disable", int'(rx_active), 0);
      end
    join
    rx_en = 1'b1;
    wait_etu(2);
    chk("R13", "aborted byte not delivered", nv - s_nv, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule